// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block sits between one core's memory port and its first-level cache controller. It tracks every request that is still in flight, keyed by cache-line address. Reads and writes are held in two separate fully associative tables. Each new request is checked against both tables, against a single locked-line register and against a limit on the number of outstanding requests. The block then answers in the same cycle with accepted, aliased or full. Only an accepted request takes a table slot.

Completions arrive with a line address and a flag that names the table. Each one frees the matching entry. When a locked read-modify-write read completes, its line becomes locked. When the matching locked write completes, the line is released. Four saturating counters record alias events, one for each pairing of the new request's class with the class of the entry it collided with.

A watchdog runs while anything is outstanding. It samples every entry's age once per threshold interval and raises a sticky deadlock flag when any entry has grown too old. Completions that match no entry raise a sticky error flag.

Top module: `line_req_tracker`

## Requirements
- R1: After reset the outstanding count, all four alias counters, `deadlock` and `cpl_err` are 0, and `req_status` is 0 while `req_valid` is low. `req_ready` is 1 from the first clock edge after reset is released.
- R2: While the outstanding count is at or above `MAX_OUT` (default 4), a valid request gets status 3 (full). Nothing is inserted and no counter moves.
- R3: Address bits below log2(`LINE_BYTES`) (bits [5:0] for the default 64-byte line) are dropped before any lookup. Two addresses that differ only in those bits name the same line.
- R4: `req_kind` codes 0 (load) and 1 (instruction fetch) are read-class and go to the read table. Codes 2 (store), 3 (RMW read), 4 (RMW write), 5 (load-linked), 6 (store-conditional), 7 (locked RMW read), 8 (locked RMW write), 9 (flush), and any other code are write-class and go to the write table.
- R5: A write-class request aliases (status 2) if its line is in the read table, or else if it is in the write table. A read-class request aliases if its line is in the write table, or else if it is in the read table. Otherwise it is accepted (status 1) into its class's table.
- R6: Each alias from R5 adds 1 to exactly one saturating counter. The counters are `cnt_st_on_ld` (write-class hitting the read table), `cnt_st_on_st` (write-class hitting the write table), `cnt_ld_on_st` (read-class hitting the write table) and `cnt_ld_on_ld` (read-class hitting the read table).
- R7: When a write-table entry of kind 7 is removed by completion, its line becomes locked. Any request to a locked line other than kind 8 gets status 2 and moves no counter. When a kind-8 entry for that line is removed, the lock is released.
- R8: A completion (`cpl_write` 0 for the read table, 1 for the write table) removes the entry whose line matches `cpl_addr`. `outstanding` always equals the number of valid entries in both tables, rising by one per acceptance and falling by one per removal.
- R9: A completion that matches no entry in the named table sets `cpl_err`, which stays set until reset and leaves `outstanding` unchanged.
- R10: The watchdog runs while requests are outstanding. It examines all entries every `wd_thresh` cycles, starting `wd_thresh` cycles after an acceptance that found it idle. It sets the sticky `deadlock` flag if any entry's age has reached `wd_thresh`. Entries completed before the examination never set it.
- R11: `req_status` is combinational in the request cycle: 0 none, 1 accepted, 2 aliased, 3 full. Precedence is full first, then the lock, then the table rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Tracker able to take requests |
| req_addr | input | ADDR_W | Byte address of the request |
| req_kind | input | 4 | Request kind code (R4) |
| req_status | output | 2 | Same-cycle answer (R11) |
| cpl_valid | input | 1 | Completion present this cycle |
| cpl_write | input | 1 | Completion targets the write table |
| cpl_addr | input | ADDR_W | Address of the completing line |
| wd_thresh | input | TH_W | Watchdog interval and age limit, nonzero |
| deadlock | output | 1 | Sticky: an entry outlived the threshold |
| cpl_err | output | 1 | Sticky: completion matched no entry |
| outstanding | output | OUT_W | Entries held in both tables |
| cnt_st_on_ld | output | CNT_W | Write-class aliases on the read table |
| cnt_st_on_st | output | CNT_W | Write-class aliases on the write table |
| cnt_ld_on_ld | output | CNT_W | Read-class aliases on the read table |
| cnt_ld_on_st | output | CNT_W | Read-class aliases on the write table |

## Verification
The embedded properties assume three things about the environment. `wd_thresh` is never zero, and it changes only while the watchdog is idle. A request carrying a locked-line kind is presented only when the controller protocol allows it. The bench meets the first two by setting the threshold once before any traffic. Before lowering it, the bench waits idle for more than one old interval so the timer has stopped. Deliberately unmatched completions are sent only in the phase that checks the error flag. Every property that relates table contents to the count holds for any interleaving of requests and completions, so the stimulus may overlap them freely.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    typedef enum logic [3:0] {
        K_LOAD   = 4'd0,
        K_IFETCH = 4'd1,
        K_STORE  = 4'd2,
        K_RMW_RD = 4'd3,
        K_RMW_WR = 4'd4,
        K_LL     = 4'd5,
        K_SC     = 4'd6,
        K_LK_RD  = 4'd7,
        K_LK_WR  = 4'd8,
        K_FLUSH  = 4'd9
    } kind_e;

    typedef enum logic [1:0] {
        ST_NONE   = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_ALIAS  = 2'd2,
        ST_FULL   = 2'd3
    } status_e;

    // alias counter slots
    localparam int A_ST_ON_LD = 0;
    localparam int A_ST_ON_ST = 1;
    localparam int A_LD_ON_LD = 2;
    localparam int A_LD_ON_ST = 3;
    localparam int A_NUM      = 4;

    function automatic logic is_read_class(input logic [3:0] k);
        return (k == K_LOAD) || (k == K_IFETCH);
    endfunction

endpackage

// File: rtl/lrt_table.sv
module lrt_table #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 26,
    parameter int TS_W    = 17,
    parameter int KIND_W  = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int OCC_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    input  logic              ins_en,
    input  logic [KIND_W-1:0] ins_kind,
    input  logic [TS_W-1:0]   now,
    input  logic              rm_en,
    input  logic [LINE_W-1:0] rm_line,
    output logic              rm_hit,
    output logic [KIND_W-1:0] rm_kind,
    input  logic [TS_W-1:0]   age_limit,
    output logic              stale,
    output logic [OCC_W-1:0]  occ
);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][LINE_W-1:0] line;
        logic [ENTRIES-1:0][KIND_W-1:0] kind;
        logic [ENTRIES-1:0][TS_W-1:0]   ts;
    } tbl_t;

    tbl_t             tbl_q, tbl_d;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rm_idx;
    logic             have_free;

    always_comb begin
        look_hit  = 1'b0;
        rm_hit    = 1'b0;
        rm_idx    = '0;
        have_free = 1'b0;
        free_idx  = '0;
        stale     = 1'b0;
        occ       = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (tbl_q.vld[i] && (tbl_q.line[i] == look_line)) look_hit = 1'b1;
            if (tbl_q.vld[i] && (tbl_q.line[i] == rm_line)) begin
                rm_hit = 1'b1;
                rm_idx = IDX_W'(i);
            end
            if (tbl_q.vld[i] && ((now - tbl_q.ts[i]) >= age_limit)) stale = 1'b1;
            occ = occ + OCC_W'(tbl_q.vld[i]);
        end
        // lowest free slot wins
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!tbl_q.vld[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        rm_kind = tbl_q.kind[rm_idx];

        tbl_d = tbl_q;
        if (rm_en && rm_hit) tbl_d.vld[rm_idx] = 1'b0;
        if (ins_en && have_free) begin
            tbl_d.vld[free_idx]  = 1'b1;
            tbl_d.line[free_idx] = look_line;
            tbl_d.kind[free_idx] = ins_kind;
            tbl_d.ts[free_idx]   = now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // R5: the parent never inserts a line this table already holds
    a_r5_insert_unique: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !look_hit)
        else $error("a_r5_insert_unique");

    // R2: the parent limit keeps a free slot available for every insert
    a_r2_insert_room: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> have_free)
        else $error("a_r2_insert_room");

    // R8: occupancy moves by at most one per cycle in either direction
    a_r8_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_en && !(rm_en && rm_hit) |=> $stable(occ))
        else $error("a_r8_occ_step");

endmodule

// File: rtl/lrt_watchdog.sv
module lrt_watchdog #(
    parameter int TH_W  = 16,
    localparam int TS_W = TH_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            busy,
    input  logic [TH_W-1:0] thresh,
    input  logic            stale_any,
    output logic [TS_W-1:0] stamp,
    output logic            deadlock
);

    typedef struct packed {
        logic            armed;
        logic [TH_W-1:0] timer;
        logic [TS_W-1:0] stamp;
        logic            dead;
    } wd_t;

    wd_t  wd_q, wd_d;
    logic sweep;

    always_comb begin
        wd_d       = wd_q;
        wd_d.stamp = wd_q.stamp + TS_W'(1);
        sweep      = wd_q.armed && (wd_q.timer == thresh - TH_W'(1));
        if (sweep) begin
            wd_d.timer = '0;
            wd_d.armed = busy;
            if (stale_any) wd_d.dead = 1'b1;
        end else if (wd_q.armed) begin
            wd_d.timer = wd_q.timer + TH_W'(1);
        end
        if (start && !wd_q.armed) begin
            wd_d.armed = 1'b1;
            wd_d.timer = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign stamp    = wd_q.stamp;
    assign deadlock = wd_q.dead;

    // R10: once raised the flag holds until reset
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |=> deadlock)
        else $error("a_r10_sticky");

    // R10: an idle watchdog never raises the flag
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_q.armed && !deadlock |=> !deadlock)
        else $error("a_r10_idle_quiet");

    // R10: with a nonzero, steady threshold the timer stays below it
    a_r10_timer_below: assert property (@(posedge clk) disable iff (!rst_n)
        wd_q.armed |-> (wd_q.timer < thresh))
        else $error("a_r10_timer_below");

endmodule

// File: rtl/lrt_alias_counters.sv
module lrt_alias_counters #(
    parameter int NUM   = 4,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [NUM-1:0][CNT_W-1:0] val;
    } ctr_t;

    ctr_t ctr_q, ctr_d;

    always_comb begin
        ctr_d = ctr_q;
        for (int i = 0; i < NUM; i++) begin
            if (inc[i] && (ctr_q.val[i] != {CNT_W{1'b1}}))
                ctr_d.val[i] = ctr_q.val[i] + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign cnt = ctr_q.val;

    // R6: one alias event per request at most
    a_r6_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc))
        else $error("a_r6_single_event");

    for (genvar g = 0; g < NUM; g++) begin : g_chk
        a_r6_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
            inc[g] && (cnt[g] != {CNT_W{1'b1}}) |=> cnt[g] == $past(cnt[g]) + CNT_W'(1))
            else $error("a_r6_ctr_step");
        a_r6_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !inc[g] |=> $stable(cnt[g]))
            else $error("a_r6_ctr_hold");
    end

endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
    import lrt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_OUT    = 4,
    parameter int TH_W       = 16,
    parameter int CNT_W      = 16,
    localparam int OUT_W     = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_kind,
    output logic [1:0]        req_status,
    input  logic              cpl_valid,
    input  logic              cpl_write,
    input  logic [ADDR_W-1:0] cpl_addr,
    input  logic [TH_W-1:0]   wd_thresh,
    output logic              deadlock,
    output logic              cpl_err,
    output logic [OUT_W-1:0]  outstanding,
    output logic [CNT_W-1:0]  cnt_st_on_ld,
    output logic [CNT_W-1:0]  cnt_st_on_st,
    output logic [CNT_W-1:0]  cnt_ld_on_ld,
    output logic [CNT_W-1:0]  cnt_ld_on_st
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int TS_W   = TH_W + 1;
    localparam int KIND_W = $bits(kind_e);

    typedef struct packed {
        logic              rdy;
        logic [OUT_W-1:0]  outstanding;
        logic              lock_vld;
        logic [LINE_W-1:0] lock_line;
        logic              err;
    } trk_t;

    trk_t trk_q, trk_d;

    logic [LINE_W-1:0] req_line, cpl_line;
    logic              off_bits_unused;
    logic              rd_hit, wr_hit, rd_rm_hit, wr_rm_hit;
    logic [KIND_W-1:0] rd_rm_kind, wr_rm_kind;
    logic              rd_stale, wr_stale;
    logic [OUT_W-1:0]  rd_occ, wr_occ;
    logic [TS_W-1:0]   stamp;
    logic              rd_ins, wr_ins, removed;
    logic [A_NUM-1:0]  alias_inc;
    logic [A_NUM-1:0][CNT_W-1:0] cnt_all;
    status_e           status;

    assign req_line        = req_addr[ADDR_W-1:OFF_W];
    assign cpl_line        = cpl_addr[ADDR_W-1:OFF_W];
    assign off_bits_unused = ^{req_addr[OFF_W-1:0], cpl_addr[OFF_W-1:0]};

    // ---------------- request decision and bookkeeping ----------------
    always_comb begin
        trk_d     = trk_q;
        status    = ST_NONE;
        alias_inc = '0;
        rd_ins    = 1'b0;
        wr_ins    = 1'b0;

        if (req_valid && trk_q.rdy) begin
            if (trk_q.outstanding >= OUT_W'(MAX_OUT)) begin
                status = ST_FULL;
            end else if (trk_q.lock_vld && (req_line == trk_q.lock_line) &&
                         (req_kind != KIND_W'(K_LK_WR))) begin
                status = ST_ALIAS;
            end else if (!is_read_class(req_kind)) begin
                if (rd_hit) begin
                    status = ST_ALIAS;
                    alias_inc[A_ST_ON_LD] = 1'b1;
                end else if (wr_hit) begin
                    status = ST_ALIAS;
                    alias_inc[A_ST_ON_ST] = 1'b1;
                end else begin
                    status = ST_ACCEPT;
                    wr_ins = 1'b1;
                end
            end else begin
                if (wr_hit) begin
                    status = ST_ALIAS;
                    alias_inc[A_LD_ON_ST] = 1'b1;
                end else if (rd_hit) begin
                    status = ST_ALIAS;
                    alias_inc[A_LD_ON_LD] = 1'b1;
                end else begin
                    status = ST_ACCEPT;
                    rd_ins = 1'b1;
                end
            end
        end

        removed = cpl_valid && (cpl_write ? wr_rm_hit : rd_rm_hit);

        trk_d.rdy         = 1'b1;
        trk_d.outstanding = trk_q.outstanding + OUT_W'(rd_ins | wr_ins) - OUT_W'(removed);
        if (cpl_valid && !removed) trk_d.err = 1'b1;

        if (cpl_valid && cpl_write && wr_rm_hit) begin
            if (wr_rm_kind == KIND_W'(K_LK_RD)) begin
                trk_d.lock_vld  = 1'b1;
                trk_d.lock_line = cpl_line;
            end else if ((wr_rm_kind == KIND_W'(K_LK_WR)) &&
                         (trk_q.lock_line == cpl_line)) begin
                trk_d.lock_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // ---------------- tables ----------------
    lrt_table #(
        .ENTRIES (MAX_OUT),
        .LINE_W  (LINE_W),
        .TS_W    (TS_W),
        .KIND_W  (KIND_W)
    ) u_rd_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_line (req_line),
        .look_hit  (rd_hit),
        .ins_en    (rd_ins),
        .ins_kind  (req_kind),
        .now       (stamp),
        .rm_en     (cpl_valid && !cpl_write),
        .rm_line   (cpl_line),
        .rm_hit    (rd_rm_hit),
        .rm_kind   (rd_rm_kind),
        .age_limit (TS_W'(wd_thresh)),
        .stale     (rd_stale),
        .occ       (rd_occ)
    );

    lrt_table #(
        .ENTRIES (MAX_OUT),
        .LINE_W  (LINE_W),
        .TS_W    (TS_W),
        .KIND_W  (KIND_W)
    ) u_wr_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_line (req_line),
        .look_hit  (wr_hit),
        .ins_en    (wr_ins),
        .ins_kind  (req_kind),
        .now       (stamp),
        .rm_en     (cpl_valid && cpl_write),
        .rm_line   (cpl_line),
        .rm_hit    (wr_rm_hit),
        .rm_kind   (wr_rm_kind),
        .age_limit (TS_W'(wd_thresh)),
        .stale     (wr_stale),
        .occ       (wr_occ)
    );

    // ---------------- watchdog and counters ----------------
    lrt_watchdog #(.TH_W(TH_W)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rd_ins | wr_ins),
        .busy      (trk_d.outstanding != '0),
        .thresh    (wd_thresh),
        .stale_any (rd_stale | wr_stale),
        .stamp     (stamp),
        .deadlock  (deadlock)
    );

    lrt_alias_counters #(.NUM(A_NUM), .CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (alias_inc),
        .cnt   (cnt_all)
    );

    assign req_ready    = trk_q.rdy;
    assign req_status   = status;
    assign cpl_err      = trk_q.err;
    assign outstanding  = trk_q.outstanding;
    assign cnt_st_on_ld = cnt_all[A_ST_ON_LD];
    assign cnt_st_on_st = cnt_all[A_ST_ON_ST];
    assign cnt_ld_on_ld = cnt_all[A_LD_ON_LD];
    assign cnt_ld_on_st = cnt_all[A_LD_ON_ST];

    // R8: the running count matches what the two tables hold
    a_r8_count_sum: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, outstanding} == ({1'b0, rd_occ} + {1'b0, wr_occ}))
        else $error("a_r8_count_sum");

    // R2: the count never exceeds the limit
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= OUT_W'(MAX_OUT))
        else $error("a_r2_no_overflow");

    // R2: a full tracker without completions keeps its count
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding >= OUT_W'(MAX_OUT)) && !cpl_valid |=> outstanding == $past(outstanding))
        else $error("a_r2_full_holds");

    // R7: a request to the locked line (other than the unlocking kind) inserts nothing
    a_r7_lock_no_insert: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.lock_vld && req_valid && (req_line == trk_q.lock_line) &&
        (req_kind != KIND_W'(K_LK_WR)) && !cpl_valid
        |=> outstanding == $past(outstanding))
        else $error("a_r7_lock_no_insert");

    // R11: no request, no status
    a_r11_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> req_status == 2'd0)
        else $error("a_r11_idle_none");

endmodule

// File: tb/line_req_tracker_test.sv
module line_req_tracker_test;

    localparam logic [1:0] S_NONE = 2'd0, S_ACC = 2'd1, S_ALI = 2'd2, S_FULL = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [31:0] req_addr;
    logic [3:0]  req_kind;
    logic [1:0]  req_status;
    logic        cpl_valid, cpl_write;
    logic [31:0] cpl_addr;
    logic [15:0] wd_thresh;
    logic        deadlock, cpl_err;
    logic [2:0]  outstanding;
    logic [15:0] cnt_st_on_ld, cnt_st_on_st, cnt_ld_on_ld, cnt_ld_on_st;

    always #4 clk = ~clk;

    line_req_tracker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_status(req_status),
        .cpl_valid(cpl_valid), .cpl_write(cpl_write), .cpl_addr(cpl_addr),
        .wd_thresh(wd_thresh), .deadlock(deadlock), .cpl_err(cpl_err),
        .outstanding(outstanding), .cnt_st_on_ld(cnt_st_on_ld),
        .cnt_st_on_st(cnt_st_on_st), .cnt_ld_on_ld(cnt_ld_on_ld),
        .cnt_ld_on_st(cnt_ld_on_st)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: status is sampled mid-cycle
    logic [1:0] mon_exp;
    string      mon_tag;
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            if (exp_q.size() == 0) begin
                chk_eq("R11 unexpected request", 1, 0);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                chk_eq(mon_tag, req_status, mon_exp);
            end
        end
    end

    task automatic send_req(input logic [31:0] a, input logic [3:0] k,
                            input logic [1:0] exp, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req_addr  = a;
        req_kind  = k;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic send_cpl(input logic [31:0] a, input logic w);
        @(posedge clk); #1;
        cpl_addr  = a;
        cpl_write = w;
        cpl_valid = 1'b1;
        @(posedge clk); #1;
        cpl_valid = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_kind = '0;
        cpl_valid = 1'b0; cpl_write = 1'b0; cpl_addr = '0; wd_thresh = 16'd100;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 outstanding", outstanding, 0);
        chk_eq("R1 ready", req_ready, 1);
        chk_eq("R1 status idle", req_status, S_NONE);
        chk_eq("R1 counters", cnt_st_on_ld + cnt_st_on_st + cnt_ld_on_ld + cnt_ld_on_st, 0);
        chk_eq("R1 flags", {deadlock, cpl_err}, 0);

        // R4/R5 read class, R3 offset bits ignored
        send_req(32'h1000, 4'd0, S_ACC, "R4 load accepted");
        send_req(32'h1010, 4'd0, S_ALI, "R3 same line load aliases");
        send_req(32'h1020, 4'd2, S_ALI, "R5 store on pending load");
        send_req(32'h2000, 4'd2, S_ACC, "R4 store accepted");
        send_req(32'h2004, 4'd0, S_ALI, "R5 load on pending store");
        send_req(32'h2000, 4'd9, S_ALI, "R5 flush on pending store");
        @(negedge clk);
        chk_eq("R6 st_on_ld", cnt_st_on_ld, 1);
        chk_eq("R6 st_on_st", cnt_st_on_st, 1);
        chk_eq("R6 ld_on_ld", cnt_ld_on_ld, 1);
        chk_eq("R6 ld_on_st", cnt_ld_on_st, 1);

        send_req(32'h3000, 4'd1, S_ACC, "R4 ifetch accepted");
        send_req(32'h4000, 4'd5, S_ACC, "R4 load-linked accepted");
        @(negedge clk);
        chk_eq("R8 outstanding four", outstanding, 4);
        send_req(32'h5000, 4'd0, S_FULL, "R2 full");
        @(negedge clk);
        chk_eq("R2 count held", outstanding, 4);
        chk_eq("R2 no counter moved", cnt_ld_on_ld + cnt_ld_on_st, 2);

        // R8 completion and re-acceptance
        send_cpl(32'h1000, 1'b0);
        @(negedge clk);
        chk_eq("R8 removal", outstanding, 3);
        send_req(32'h1008, 4'd0, S_ACC, "R8 line free after completion");
        send_cpl(32'h1000, 1'b0);
        send_cpl(32'h3000, 1'b0);
        send_cpl(32'h2000, 1'b1);
        send_cpl(32'h4000, 1'b1);
        @(negedge clk);
        chk_eq("R8 drained", outstanding, 0);
        chk_eq("R9 no error yet", cpl_err, 0);

        // R9 / R2: the rejected request was never stored
        send_cpl(32'h5000, 1'b0);
        @(negedge clk);
        chk_eq("R9 unmatched completion", cpl_err, 1);
        chk_eq("R9 count unchanged", outstanding, 0);

        // R7 locked line
        send_req(32'h8000, 4'd7, S_ACC, "R7 locked read accepted");
        send_cpl(32'h8000, 1'b1);
        send_req(32'h8008, 4'd0, S_ALI, "R7 load blocked by lock");
        send_req(32'h8000, 4'd2, S_ALI, "R7 store blocked by lock");
        send_req(32'h9000, 4'd0, S_ACC, "R7 other line unaffected");
        send_cpl(32'h9000, 1'b0);
        @(negedge clk);
        chk_eq("R7 lock alias not counted", cnt_st_on_ld + cnt_st_on_st + cnt_ld_on_ld + cnt_ld_on_st, 4);
        send_req(32'h8000, 4'd8, S_ACC, "R7 unlocking write passes");
        send_cpl(32'h8000, 1'b1);
        send_req(32'h8000, 4'd0, S_ACC, "R7 line released");
        send_cpl(32'h8000, 1'b0);
        @(negedge clk);
        chk_eq("R7 drained", outstanding, 0);

        // R10 watchdog: let the old interval run out, then shorten it
        repeat (120) @(posedge clk);
        #1 wd_thresh = 16'd20;
        send_req(32'hA000, 4'd0, S_ACC, "R10 short-lived load");
        repeat (8) @(posedge clk);
        send_cpl(32'hA000, 1'b0);
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk_eq("R10 no deadlock when completed early", deadlock, 0);
        send_req(32'hB000, 4'd2, S_ACC, "R10 store left pending");
        repeat (15) @(posedge clk);
        @(negedge clk);
        chk_eq("R10 not yet at threshold", deadlock, 0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk_eq("R10 deadlock raised", deadlock, 1);
        chk_eq("R11 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule